// File: doc/BRIEF.md
# Page Translation Cache with Referenced/Modified Tracking

A small fully associative cache of final virtual-page to physical-page translations. Each entry stores a virtual page number, a physical page number and four flags: writable, no-execute, referenced and modified. A lookup port takes a virtual page number and an access kind. It either completes at once with the physical page number, reports a miss so that an external walker can fetch the mapping, or reports a permission fault. A fill port installs a completed walk. Two flush inputs drop cached mappings, either all of them or only the one for a given virtual page.

Permission checks on a hit use only the flags held in the entry and never touch memory. Some hits find a cached referenced or modified bit still clear: any access with referenced clear, or a store with modified clear. Such a lookup is accepted, and the block then raises a flag-update request toward the memory side. The port stalls until that request is acknowledged. The access then completes, and the entry carries the newly set bits. When the cached bit is already set, nothing is requested, even if the page table in memory has the bit clear. The cache does not watch writes to page-table memory, so software must flush after editing a mapping.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid: any lookup reports a miss, `lk_ready` is 1 and `upd_req` is 0.
- R2: A lookup that hits, passes the permission check and needs no flag update asserts `lk_done` in the same cycle, with `lk_ppn` equal to the installed physical page number.
- R3: A lookup with no valid matching entry asserts `lk_miss` in the same cycle, and neither `lk_done` nor `lk_fault`.
- R4: A fill installs the mapping with its four flags. A fill whose virtual page is already cached overwrites that same entry, so no other mapping is evicted.
- R5: A fill of a new page uses the lowest-numbered invalid entry. If all entries are valid, it uses a round-robin pointer that starts at entry 0 after reset and advances by one only when it has been used.
- R6: Access kind `lk_acc` is encoded 0 = load, 1 = store, 2 = instruction fetch (3 is treated as a load). A store to a non-writable page and a fetch from a no-execute page assert `lk_fault` in the same cycle and never raise `upd_req`. A load never faults on a hit.
- R7: A permitted load or fetch that hits an entry with its referenced bit clear raises `upd_req` from the next cycle, with `upd_vpn` equal to the page and `upd_set_dirty` equal to 0. Afterwards the entry's referenced bit is set.
- R8: A permitted store that hits an entry with its modified bit clear (or its referenced bit clear) raises `upd_req` from the next cycle with `upd_set_dirty` equal to 1. Afterwards both bits are set in the entry.
- R9: While `upd_req` is high, `lk_ready` is 0 and `upd_vpn` holds steady until `upd_ack`. In the acknowledge cycle `lk_done` is 1 with the page's physical number, and the next cycle returns to ready.
- R10: A hit whose needed bits are already set in the entry never raises `upd_req`, whatever the page table in memory holds.
- R11: `flush_all` invalidates every entry at the next clock edge.
- R12: `flush_one` invalidates only the entry whose virtual page equals `flush_vpn`. Every other mapping stays usable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lk_ready | output | 1 | Lookup port can accept a request |
| lk_done | output | 1 | Translation completed |
| lk_ppn | output | PPN_W | Physical page number, valid with lk_done |
| lk_miss | output | 1 | No cached mapping, walk needed |
| lk_fault | output | 1 | Permission violation on a hit |
| upd_req | output | 1 | Flag update to page-table memory requested |
| upd_vpn | output | VPN_W | Page whose flags are to be set |
| upd_set_dirty | output | 1 | Update also sets the modified bit |
| upd_ack | input | 1 | Memory side has performed the flag update |
| fill_valid | input | 1 | Install a completed walk |
| fill_vpn | input | VPN_W | Virtual page of the fill |
| fill_ppn | input | PPN_W | Physical page of the fill |
| fill_wr | input | 1 | Page writable |
| fill_nx | input | 1 | Page not executable |
| fill_ref | input | 1 | Referenced bit from memory |
| fill_dirty | input | 1 | Modified bit from memory |
| flush_all | input | 1 | Invalidate all entries |
| flush_one | input | 1 | Invalidate the entry for flush_vpn |
| flush_vpn | input | VPN_W | Page to invalidate |

## Verification
The cache is filled with sixteen pages whose four flags sweep all sixteen combinations. Each page is then looked up as a load, a store and a fetch, twice over. The first pass separates fault, immediate hit and update-with-stall by the flag pattern, and the second pass shows that bits set by the first pass suppress any new request. Pages outside the filled set separate misses from hits. A sequence of fills into a full cache, mixed with a single-page flush, distinguishes lowest-invalid placement from round-robin placement and shows that the pointer moves only when it is used. Refilling a cached page and a final global flush show replacement in place and total invalidation.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_UPD  = 1'b1
    } upd_state_e;

    typedef struct packed {
        logic wr;
        logic nx;
        logic ref_bit;
        logic dirty;
    } perm_t;

    function automatic logic perm_violation(perm_t p, logic is_store, logic is_fetch);
        return (is_store && !p.wr) || (is_fetch && p.nx);
    endfunction

    function automatic logic flags_stale(perm_t p, logic is_store);
        return !p.ref_bit || (is_store && !p.dirty);
    endfunction

    function automatic perm_t flags_marked(perm_t p, logic set_dirty);
        perm_t r;
        r         = p;
        r.ref_bit = 1'b1;
        r.dirty   = p.dirty | set_dirty;
        return r;
    endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]            valid_vec,
    input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_vec,
    input  logic [VPN_W-1:0]              key,
    output logic                          hit,
    output logic [IDX_W-1:0]              idx
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = valid_vec[g] && (vpn_vec[g] == key);
    end

    assign hit = |eq;

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               take,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0] rr_q;
    logic             free_found;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        victim = free_found ? free_idx : rr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (take && !free_found) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/xlat_perm.sv
module xlat_perm
    import xlat_pkg::*;
(
    input  perm_t flags,
    input  logic  is_store,
    input  logic  is_fetch,
    output logic  fault,
    output logic  need_upd
);
    assign fault    = perm_violation(flags, is_store, is_fetch);
    assign need_upd = !fault && flags_stale(flags, is_store);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [1:0]       lk_acc,
    output logic             lk_ready,
    output logic             lk_done,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic             upd_req,
    output logic [VPN_W-1:0] upd_vpn,
    output logic             upd_set_dirty,
    input  logic             upd_ack,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_wr,
    input  logic             fill_nx,
    input  logic             fill_ref,
    input  logic             fill_dirty,
    input  logic             flush_all,
    input  logic             flush_one,
    input  logic [VPN_W-1:0] flush_vpn
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    // entry storage
    logic [ENTRIES-1:0]            vld_q;
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
    logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
    perm_t                         perm_q [ENTRIES];

    // pending flag update
    upd_state_e       state_q;
    logic [IDX_W-1:0] upd_idx_q;
    logic [VPN_W-1:0] upd_vpn_q;
    logic [PPN_W-1:0] upd_ppn_q;
    logic             upd_dirty_q;

    // lookup path
    logic             lk_hit;
    logic [IDX_W-1:0] lk_idx;
    logic             is_store;
    logic             is_fetch;
    logic             pf;
    logic             stale;
    logic             go;

    // fill / flush path
    logic             fl_hit;
    logic [IDX_W-1:0] fl_idx;
    logic             fo_hit;
    logic [IDX_W-1:0] fo_idx;
    logic [IDX_W-1:0] victim;
    logic [IDX_W-1:0] fill_slot;
    logic             ack_live;
    perm_t            upd_flags;
    perm_t            fill_flags;

    xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
        .valid_vec (vld_q),
        .vpn_vec   (vpn_q),
        .key       (lk_vpn),
        .hit       (lk_hit),
        .idx       (lk_idx)
    );

    xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill_match (
        .valid_vec (vld_q),
        .vpn_vec   (vpn_q),
        .key       (fill_vpn),
        .hit       (fl_hit),
        .idx       (fl_idx)
    );

    xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_flush_match (
        .valid_vec (vld_q),
        .vpn_vec   (vpn_q),
        .key       (flush_vpn),
        .hit       (fo_hit),
        .idx       (fo_idx)
    );

    xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (vld_q),
        .take      (fill_valid && !fl_hit),
        .victim    (victim)
    );

    assign is_store = (lk_acc == ACC_STORE);
    assign is_fetch = (lk_acc == ACC_FETCH);

    xlat_perm u_perm (
        .flags    (perm_q[lk_idx]),
        .is_store (is_store),
        .is_fetch (is_fetch),
        .fault    (pf),
        .need_upd (stale)
    );

    assign lk_ready = (state_q == ST_IDLE);
    assign go       = lk_valid && lk_ready;

    always_comb begin
        lk_miss  = go && !lk_hit;
        lk_fault = go && lk_hit && pf;
        lk_done  = 1'b0;
        lk_ppn   = '0;
        if (state_q == ST_UPD) begin
            if (upd_ack) begin
                lk_done = 1'b1;
                lk_ppn  = upd_ppn_q;
            end
        end else if (go && lk_hit && !pf && !stale) begin
            lk_done = 1'b1;
            lk_ppn  = ppn_q[lk_idx];
        end
    end

    assign upd_req       = (state_q == ST_UPD);
    assign upd_vpn       = upd_vpn_q;
    assign upd_set_dirty = upd_dirty_q;

    assign ack_live   = (state_q == ST_UPD) && upd_ack && vld_q[upd_idx_q]
                        && (vpn_q[upd_idx_q] == upd_vpn_q);
    assign upd_flags  = flags_marked(perm_q[upd_idx_q], upd_dirty_q);
    assign fill_slot  = fl_hit ? fl_idx : victim;
    assign fill_flags = '{wr: fill_wr, nx: fill_nx, ref_bit: fill_ref, dirty: fill_dirty};

    // control and valid bits
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            vld_q       <= '0;
            upd_idx_q   <= '0;
            upd_vpn_q   <= '0;
            upd_ppn_q   <= '0;
            upd_dirty_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (go && lk_hit && !pf && stale) begin
                        state_q     <= ST_UPD;
                        upd_idx_q   <= lk_idx;
                        upd_vpn_q   <= lk_vpn;
                        upd_ppn_q   <= ppn_q[lk_idx];
                        upd_dirty_q <= is_store;
                    end
                end
                ST_UPD: begin
                    if (upd_ack) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
            if (flush_one && fo_hit) vld_q[fo_idx] <= 1'b0;
            if (fill_valid)          vld_q[fill_slot] <= 1'b1;
            if (flush_all)           vld_q <= '0;
        end
    end

    // payload storage, no reset needed
    always_ff @(posedge clk) begin
        if (ack_live) perm_q[upd_idx_q] <= upd_flags;
        if (fill_valid) begin
            vpn_q[fill_slot]  <= fill_vpn;
            ppn_q[fill_slot]  <= fill_ppn;
            perm_q[fill_slot] <= fill_flags;
        end
    end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int VPN_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic             lk_ready,
    input logic             lk_done,
    input logic             lk_miss,
    input logic             lk_fault,
    input logic             upd_req,
    input logic [VPN_W-1:0] upd_vpn,
    input logic             upd_ack,
    input logic             fill_valid,
    input logic             flush_all
);
    // R9
    stall_while_upd_chk: assert property (@(posedge clk) disable iff (rst)
        upd_req |-> !lk_ready);

    // R9
    upd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_req && !upd_ack) |=> (upd_req && $stable(upd_vpn)));

    // R9
    ack_completes_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_req && upd_ack) |-> lk_done);

    // R9
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_req && upd_ack) |=> lk_ready);

    // R3
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lk_done, lk_miss, lk_fault}));

    // R6
    fault_no_upd_chk: assert property (@(posedge clk) disable iff (rst)
        lk_fault |=> !upd_req);

    // R11
    flush_all_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (flush_all && !fill_valid) |=> ((lk_valid && lk_ready) |-> lk_miss));
endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lk_valid   (lk_valid),
    .lk_ready   (lk_ready),
    .lk_done    (lk_done),
    .lk_miss    (lk_miss),
    .lk_fault   (lk_fault),
    .upd_req    (upd_req),
    .upd_vpn    (upd_vpn),
    .upd_ack    (upd_ack),
    .fill_valid (fill_valid),
    .flush_all  (flush_all)
);

// File: tb/tb_xlat_cache.sv
`timescale 1ns/1ps
module tb_xlat_cache;
    localparam int N  = 16;
    localparam int VW = 8;
    localparam int PW = 8;

    localparam int K_DONE  = 0;
    localparam int K_MISS  = 1;
    localparam int K_FAULT = 2;
    localparam int K_UPD   = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lk_valid = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic [1:0]    lk_acc = '0;
    logic          lk_ready, lk_done, lk_miss, lk_fault;
    logic [PW-1:0] lk_ppn;
    logic          upd_req, upd_set_dirty;
    logic [VW-1:0] upd_vpn;
    logic          upd_ack = 1'b0;
    logic          fill_valid = 1'b0;
    logic [VW-1:0] fill_vpn = '0;
    logic [PW-1:0] fill_ppn = '0;
    logic          fill_wr = 1'b0, fill_nx = 1'b0, fill_ref = 1'b0, fill_dirty = 1'b0;
    logic          flush_all = 1'b0, flush_one = 1'b0;
    logic [VW-1:0] flush_vpn = '0;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    int m_wr [N];
    int m_nx [N];
    int m_ref[N];
    int m_dty[N];

    always #10 clk = ~clk;

    xlat_cache #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW)) dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_acc(lk_acc),
        .lk_ready(lk_ready), .lk_done(lk_done), .lk_ppn(lk_ppn),
        .lk_miss(lk_miss), .lk_fault(lk_fault),
        .upd_req(upd_req), .upd_vpn(upd_vpn), .upd_set_dirty(upd_set_dirty),
        .upd_ack(upd_ack),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_wr(fill_wr), .fill_nx(fill_nx), .fill_ref(fill_ref), .fill_dirty(fill_dirty),
        .flush_all(flush_all), .flush_one(flush_one), .flush_vpn(flush_vpn)
    );

    function automatic int pmap(int v);
        return (v * 37 + 11) % 256;
    endfunction

    task automatic chk(input string rq, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, got, exp);
        end
    endtask

    task automatic fill(input int v, input int p, input int wr, input int nx,
                        input int rf, input int dt);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_vpn   = VW'(v);
        fill_ppn   = PW'(p);
        fill_wr    = wr[0];
        fill_nx    = nx[0];
        fill_ref   = rf[0];
        fill_dirty = dt[0];
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic flush(input bit all, input int v);
        @(negedge clk);
        flush_all = all;
        flush_one = !all;
        flush_vpn = VW'(v);
        @(posedge clk);
        @(negedge clk);
        flush_all = 1'b0;
        flush_one = 1'b0;
    endtask

    task automatic lookup(input int v, input int a, input int kind, input int eppn,
                          input int edirty, input string rq);
        int got;
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vpn   = VW'(v);
        lk_acc   = a[1:0];
        #1;
        got = lk_done ? K_DONE : lk_miss ? K_MISS : lk_fault ? K_FAULT : K_UPD;
        chk(rq, $sformatf("outcome vpn=%0d acc=%0d", v, a), got, kind);
        if (kind == K_DONE) chk(rq, "ppn", int'(lk_ppn), eppn);
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
        #1;
        if (kind == K_UPD) begin
            chk(rq, "upd_req raised", int'(upd_req), 1);
            chk(rq, "upd_vpn", int'(upd_vpn), v);
            chk(rq, "upd_set_dirty", int'(upd_set_dirty), edirty);
            @(posedge clk);
            @(negedge clk);
            #1;
            chk("R9", "stall ready", int'(lk_ready), 0);
            chk("R9", "stall upd_req", int'(upd_req), 1);
            upd_ack = 1'b1;
            #1;
            chk("R9", "done on ack", int'(lk_done), 1);
            chk("R9", "ppn on ack", int'(lk_ppn), eppn);
            @(posedge clk);
            @(negedge clk);
            upd_ack = 1'b0;
            #1;
            chk("R9", "release", int'(lk_ready && !upd_req), 1);
        end else begin
            chk(rq == "R6" ? "R6" : "R10", "no upd_req", int'(upd_req), 0);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        chk("R1", "ready after reset", int'(lk_ready), 1);
        chk("R1", "no upd after reset", int'(upd_req), 0);
        for (int v = 0; v < 4; v++) lookup(v * 5, 0, K_MISS, 0, 0, "R1");

        // R4 R5: sixteen pages, flags sweep all combinations
        for (int v = 0; v < N; v++) begin
            m_wr[v]  = v & 1;
            m_nx[v]  = (v >> 1) & 1;
            m_ref[v] = (v >> 2) & 1;
            m_dty[v] = (v >> 3) & 1;
            fill(v, pmap(v), m_wr[v], m_nx[v], m_ref[v], m_dty[v]);
        end

        // R2 R6 R7 R8 R10: two passes over every page and access kind
        for (int pass = 0; pass < 2; pass++) begin
            for (int v = 0; v < N; v++) begin
                for (int a = 0; a < 3; a++) begin
                    bit st, fe;
                    st = (a == 1);
                    fe = (a == 2);
                    if ((st && m_wr[v] == 0) || (fe && m_nx[v] == 1)) begin
                        lookup(v, a, K_FAULT, 0, 0, "R6");
                    end else if (m_ref[v] == 0 || (st && m_dty[v] == 0)) begin
                        lookup(v, a, K_UPD, pmap(v), int'(st), st ? "R8" : "R7");
                        m_ref[v] = 1;
                        if (st) m_dty[v] = 1;
                    end else begin
                        lookup(v, a, K_DONE, pmap(v), 0, pass == 0 ? "R2" : "R10");
                    end
                end
            end
        end

        // R3: pages never installed
        for (int v = N; v < N + 5; v++) lookup(v, 1, K_MISS, 0, 0, "R3");

        // R4: refill of a cached page replaces it in place
        fill(3, 77, 1, 0, 1, 1);
        lookup(3, 0, K_DONE, 77, 0, "R4");
        for (int v = 0; v < N; v++) begin
            if (v != 3) lookup(v, 0, K_DONE, pmap(v), 0, "R4");
        end

        // R5: full cache, round-robin from entry 0
        fill(100, pmap(100), 1, 0, 1, 1);
        lookup(0, 0, K_MISS, 0, 0, "R5");
        lookup(100, 0, K_DONE, pmap(100), 0, "R5");
        fill(101, pmap(101), 1, 0, 1, 1);
        lookup(1, 0, K_MISS, 0, 0, "R5");
        lookup(101, 0, K_DONE, pmap(101), 0, "R5");

        // R12: drop one page only
        flush(1'b0, 5);
        lookup(5, 0, K_MISS, 0, 0, "R12");
        lookup(6, 0, K_DONE, pmap(6), 0, "R12");
        lookup(4, 0, K_DONE, pmap(4), 0, "R12");

        // R5: free entry first, pointer untouched, then pointer at entry 2
        fill(200, pmap(200), 1, 0, 1, 1);
        lookup(2, 0, K_DONE, pmap(2), 0, "R5");
        fill(201, pmap(201), 1, 0, 1, 1);
        lookup(2, 0, K_MISS, 0, 0, "R5");
        lookup(200, 0, K_DONE, pmap(200), 0, "R5");
        lookup(201, 0, K_DONE, pmap(201), 0, "R5");
        lookup(3, 0, K_DONE, 77, 0, "R5");

        // R11
        flush(1'b1, 0);
        lookup(100, 0, K_MISS, 0, 0, "R11");
        for (int v = 3; v < N; v++) lookup(v, 0, K_MISS, 0, 0, "R11");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule